// File: doc/BRIEF.md
# Paged MDIO 32-bit register bridge

This block lets a host issue 32-bit register reads, writes and read-modify-writes to an external switch that is only reachable over a Clause 22 MDIO management bus. Each request carries a byte address. The bridge cuts that address into three parts: a page number, a small PHY-address offset and an even register number. It then runs a fixed series of serial management frames on MDC/MDIO.

Every access starts with a frame that stores the page number in a page-select register. The bridge then waits a settle time. After that it moves the 32-bit word as two 16-bit halves, low half first. A read-modify-write reads both halves, merges the new bits under a mask, and writes both halves back. Setting bits and clearing bits are special cases of the read-modify-write. When the sequence is complete the bridge returns the resulting word and pulses a completion flag.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset, and whenever the bridge is idle, `req_ready` is 1, `done` is 0, `mdc` is low and `mdio_oe` is 0.
- R2: The byte address is split as follows. Page = addr[17:9]. PHY offset = addr[8:6]. Register = {addr[5:2], 0}. Register bit 0 is always 0, so address bits 1:0 have no effect.
- R3: The first frame of every request is a write of the page value, zero-extended to 16 bits, to PHY address 0x18, register 0.
- R4: At least SETTLE_US microseconds pass between the last MDC rising edge of the page frame and the first MDC rising edge of the next frame. This is SETTLE_US × CLK_HZ/10^6 clock cycles, which is 625 with the default parameters.
- R5: Data frames go to PHY address 0x10 | offset. For a write (req_op 01), word bits 15:0 are written to the even register first. Bits 31:16 are written to register + 1 after that.
- R6: A read (req_op 00) reads the even register first and register + 1 second. The bridge then returns {second, first} on `rdata`. `rdata` changes only in the cycle in which `done` is 1. A write returns the written word.
- R7: A read-modify-write (req_op[1] = 1) makes five frames: page write, read low, read high, write low, write high. The value written is (old & ~req_mask) | req_wdata, and the same value is returned on `rdata`.
- R8: A read-modify-write with an all-zero mask sets the bits given in req_wdata. A read-modify-write with an all-zero req_wdata clears the bits given in req_mask.
- R9: Each frame has this layout: 32 ones, start 01, opcode (10 for read, 01 for write), 5-bit PHY address, 5-bit register, turnaround, 16 data bits MSB first. Write frames drive turnaround 10. Read frames release `mdio_oe` for the turnaround and data bits. MDC toggles only while a request is in progress.
- R10: A request is taken only while `req_ready` is 1. A `req_valid` pulse while the bridge is busy makes no frames and no change in the switch.
- R11: `done` is high for exactly one cycle at the end of each request, and the bridge is ready in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 2 | 00 read, 01 write, 1x read-modify-write |
| req_addr | input | ADDR_W | Byte address of the 32-bit register |
| req_wdata | input | 32 | Write data, or the bits ORed in for a read-modify-write |
| req_mask | input | 32 | Bits cleared before the OR in a read-modify-write |
| req_ready | output | 1 | Bridge idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Returned word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven toward the switch |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Serial data from the switch |

## Verification
A wrong sequencer step shows up at once on the bus, as a wrong PHY address, register or opcode in the next frame header, within one 64-bit frame time. A corrupted merge or capture register shows up as a wrong half-word written back, or a wrong `rdata` at the `done` pulse of that same request. A settle counter that ends early shows up as a short gap between the first and second frames. A stuck busy flag shows up as `req_ready` never coming back, or as `done` repeating, and is seen within one request time.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int PAGE_W = 9;
    localparam int OFFS_W = 3;
    localparam int FRAME_BITS = 64;
    localparam logic [4:0] PAGE_SEL_PHY = 5'h18;
    localparam logic [1:0] DATA_PHY_HI = 2'b10;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT,
        SQ_SETTLE
    } seq_state_e;
endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
    parameter int MDC_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_bridge_pkg::*;

    localparam int DW = (MDC_DIV > 1) ? $clog2(MDC_DIV) : 1;
    localparam logic [5:0] LAST_BIT = 6'(FRAME_BITS - 1);
    localparam logic [5:0] TA_BIT = 6'd46;
    localparam logic [5:0] DATA_BIT = 6'd48;

    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic [DW-1:0]         div;
        logic                  mdc;
        logic [5:0]            bitn;
        logic [FRAME_BITS-1:0] sh;
        logic [HALF_W-1:0]     rx;
        logic                  done;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        eng_d.done = 1'b0;
        if (!eng_q.busy) begin
            if (start) begin
                eng_d.busy = 1'b1;
                eng_d.rd   = rd;
                eng_d.div  = '0;
                eng_d.mdc  = 1'b0;
                eng_d.bitn = '0;
                eng_d.sh   = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, regad,
                              (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wdata)};
            end
        end else if (eng_q.div == DW'(MDC_DIV - 1)) begin
            eng_d.div = '0;
            eng_d.mdc = !eng_q.mdc;
            if (!eng_q.mdc) begin
                // rising MDC: sample returned data bits
                if (eng_q.rd && eng_q.bitn >= DATA_BIT)
                    eng_d.rx = {eng_q.rx[HALF_W-2:0], mdio_i};
            end else if (eng_q.bitn == LAST_BIT) begin
                eng_d.busy = 1'b0;
                eng_d.done = 1'b1;
            end else begin
                eng_d.bitn = eng_q.bitn + 6'd1;
                eng_d.sh   = {eng_q.sh[FRAME_BITS-2:0], 1'b1};
            end
        end else begin
            eng_d.div = eng_q.div + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign done    = eng_q.done;
    assign rdata   = eng_q.rx;
    assign mdc     = eng_q.mdc;
    assign mdio_o  = eng_q.busy ? eng_q.sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = eng_q.busy && !(eng_q.rd && eng_q.bitn >= TA_BIT);
endmodule

// File: rtl/mdio_page_sequencer.sv
module mdio_page_sequencer #(
    parameter int ADDR_W     = 18,
    parameter int SETTLE_CYC = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       req_mask,
    output logic              req_ready,
    output logic              done,
    output logic [31:0]       rdata,
    output logic              eng_start,
    output logic              eng_rd,
    output logic [4:0]        eng_phy,
    output logic [4:0]        eng_reg,
    output logic [15:0]       eng_wdata,
    input  logic              eng_done,
    input  logic [15:0]       eng_rdata
);
    import mdio_bridge_pkg::*;

    localparam int CW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [2:0]        step;
        logic              rmw;
        logic              wr;
        logic [PAGE_W-1:0] page;
        logic [OFFS_W-1:0] off;
        logic [3:0]        regbase;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] val;
        logic [WORD_W-1:0] word;
        logic [CW-1:0]     cnt;
        logic              done;
        logic [WORD_W-1:0] rdata;
    } seq_t;

    seq_t sq_d, sq_q;
    logic [2:0] last_step;

    assign last_step = sq_q.rmw ? 3'd4 : 3'd2;

    always_comb begin
        sq_d = sq_q;
        sq_d.done = 1'b0;
        case (sq_q.st)
            SQ_IDLE: if (req_valid) begin
                sq_d.st      = SQ_LAUNCH;
                sq_d.step    = 3'd0;
                sq_d.rmw     = req_op[1];
                sq_d.wr      = (req_op == 2'b01);
                sq_d.page    = req_addr[17:9];
                sq_d.off     = req_addr[8:6];
                sq_d.regbase = req_addr[5:2];
                sq_d.mask    = req_mask;
                sq_d.val     = req_wdata;
                sq_d.word    = req_wdata;
            end
            SQ_LAUNCH: sq_d.st = SQ_WAIT;
            SQ_WAIT: if (eng_done) begin
                if (sq_q.step == 3'd1 && !sq_q.wr)
                    sq_d.word[15:0] = eng_rdata;
                if (sq_q.step == 3'd2 && !sq_q.wr) begin
                    sq_d.word[31:16] = eng_rdata;
                    if (sq_q.rmw)
                        sq_d.word = ({eng_rdata, sq_q.word[15:0]} & ~sq_q.mask) | sq_q.val;
                end
                if (sq_q.step == 3'd0) begin
                    sq_d.st  = SQ_SETTLE;
                    sq_d.cnt = '0;
                end else if (sq_q.step == last_step) begin
                    sq_d.st    = SQ_IDLE;
                    sq_d.done  = 1'b1;
                    sq_d.rdata = sq_d.word;
                end else begin
                    sq_d.step = sq_q.step + 3'd1;
                    sq_d.st   = SQ_LAUNCH;
                end
            end
            SQ_SETTLE: begin
                if (sq_q.cnt == CW'(SETTLE_CYC - 1)) begin
                    sq_d.step = 3'd1;
                    sq_d.st   = SQ_LAUNCH;
                end else begin
                    sq_d.cnt = sq_q.cnt + CW'(1);
                end
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    logic first_step, low_half;
    assign first_step = (sq_q.step == 3'd0);
    assign low_half   = (sq_q.step == 3'd1) || (sq_q.step == 3'd3);

    assign req_ready = (sq_q.st == SQ_IDLE);
    assign done      = sq_q.done;
    assign rdata     = sq_q.rdata;
    assign eng_start = (sq_q.st == SQ_LAUNCH);
    assign eng_rd    = !sq_q.wr && (sq_q.step == 3'd1 || sq_q.step == 3'd2);
    assign eng_phy   = first_step ? PAGE_SEL_PHY : {DATA_PHY_HI, sq_q.off};
    assign eng_reg   = first_step ? 5'd0 : {sq_q.regbase, !low_half};
    assign eng_wdata = first_step ? {{(HALF_W-PAGE_W){1'b0}}, sq_q.page}
                     : (low_half ? sq_q.word[15:0] : sq_q.word[31:16]);
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge #(
    parameter int CLK_HZ    = 125_000_000,
    parameter int SETTLE_US = 5,
    parameter int MDC_DIV   = 4,
    parameter int ADDR_W    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       req_mask,
    output logic              req_ready,
    output logic              done,
    output logic [31:0]       rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;

    logic        eng_start, eng_rd, eng_done;
    logic [4:0]  eng_phy, eng_reg;
    logic [15:0] eng_wdata, eng_rdata;

    mdio_page_sequencer #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .eng_start(eng_start), .eng_rd(eng_rd), .eng_phy(eng_phy),
        .eng_reg(eng_reg), .eng_wdata(eng_wdata),
        .eng_done(eng_done), .eng_rdata(eng_rdata)
    );

    mdio_frame_engine #(.MDC_DIV(MDC_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(eng_start), .rd(eng_rd), .phy(eng_phy), .regad(eng_reg),
        .wdata(eng_wdata), .done(eng_done), .rdata(eng_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        done,
    input logic [31:0] rdata,
    input logic        mdc,
    input logic        mdio_oe
);
    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mdc && !mdio_oe));

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata));

    assert_mdc_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> !req_ready);

    assert_accept_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

bind mdio_page_bridge mdio_page_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .rdata(rdata), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/mdio_page_bridge_bench.sv
module mdio_page_bridge_bench;
    localparam int SETTLE_CYC = 625;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [17:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_mask = '0;
    logic        req_ready, done, mdc, mdio_o, mdio_oe;
    logic [31:0] rdata;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    mdio_page_bridge u_mdio_page_bridge (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;

    // ---------------- switch-side model ----------------
    logic [15:0] mem [int];
    logic [8:0]  mdl_page = '0;
    int          k = 0;
    logic [63:0] cap = '0;
    logic        cur_rd = 1'b0;
    logic        oe_bad = 1'b0;
    logic [15:0] drv = '0;
    int          first_c = 0;
    int          fcount = 0;
    logic        f_rd   [8];
    logic [4:0]  f_phy  [8];
    logic [4:0]  f_reg  [8];
    logic [15:0] f_data [8];
    logic [1:0]  f_st   [8];
    logic [1:0]  f_op   [8];
    logic [1:0]  f_ta   [8];
    logic        f_pre  [8];
    logic        f_oeok [8];
    int          f_first[8];
    int          f_last [8];

    function automatic int mkey(input logic [8:0] pg, input logic [4:0] ph, input logic [4:0] rg);
        return int'({pg, ph, rg});
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge mdc) begin
        logic bitv;
        logic exp_oe;
        bitv = mdio_oe ? mdio_o : mdio_i;
        if (k == 0) begin first_c = cyc; oe_bad = 1'b0; cur_rd = 1'b0; end
        exp_oe = !(cur_rd && k >= 46);
        if (mdio_oe != exp_oe) oe_bad = 1'b1;
        cap[63-k] = bitv;
        if (k == 35) cur_rd = (cap[29:28] == 2'b10);
        if (k == 45 && cur_rd)
            drv = mem.exists(mkey(mdl_page, cap[27:23], cap[22:18])) ?
                  mem[mkey(mdl_page, cap[27:23], cap[22:18])] : 16'h0000;
        if (k == 63) begin
            if (!cur_rd) begin
                if (cap[27:23] == 5'h18 && cap[22:18] == 5'd0) mdl_page = cap[8:0];
                else mem[mkey(mdl_page, cap[27:23], cap[22:18])] = cap[15:0];
            end
            if (fcount < 8) begin
                f_rd[fcount] = cur_rd;  f_phy[fcount] = cap[27:23];
                f_reg[fcount] = cap[22:18]; f_data[fcount] = cap[15:0];
                f_st[fcount] = cap[31:30]; f_op[fcount] = cap[29:28];
                f_ta[fcount] = cap[17:16]; f_pre[fcount] = (cap[63:32] == 32'hFFFF_FFFF);
                f_oeok[fcount] = !oe_bad; f_first[fcount] = first_c; f_last[fcount] = cyc;
            end
            fcount = fcount + 1;
            k = 0;
        end else begin
            k = k + 1;
        end
    end

    always @(negedge mdc) begin
        if (cur_rd && k >= 48 && k <= 63) mdio_i = drv[63-k];
        else if (cur_rd && k == 47)       mdio_i = 1'b0;
        else                              mdio_i = 1'b1;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_frame(input string req, input int i, input logic rd,
                             input logic [4:0] ph, input logic [4:0] rg, input logic [15:0] dat);
        chk(req, $sformatf("frame%0d kind", i), {31'd0, f_rd[i]}, {31'd0, rd});
        chk(req, $sformatf("frame%0d phy", i), {27'd0, f_phy[i]}, {27'd0, ph});
        chk(req, $sformatf("frame%0d reg", i), {27'd0, f_reg[i]}, {27'd0, rg});
        chk(req, $sformatf("frame%0d data", i), {16'd0, f_data[i]}, {16'd0, dat});
    endtask

    logic [31:0] got;

    task automatic run_op(input logic [1:0] op, input logic [17:0] a,
                          input logic [31:0] wd, input logic [31:0] mk, input bit inject);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        fcount = 0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_mask = mk;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            repeat (20) @(negedge clk);
            chk("R10", "ready while busy", {31'd0, req_ready}, 32'd0);
            req_valid = 1'b1; req_op = 2'b01; req_addr = 18'h00444;
            req_wdata = 32'hCAFE_F00D;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        got = rdata;
        chk("R11", "ready with done", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        chk("R11", "done width", {31'd0, done}, 32'd0);
    endtask

    // addr A: page 0x155, offset 5, register 0x16 -> phy 0x15
    localparam logic [17:0] ADDR_A = 18'h2AB6C;
    // addr B: page 1, offset 0, register 6, low bits 11
    localparam logic [17:0] ADDR_B = 18'h0020F;
    // addr C: page 0x1FF, offset 7, register 0x1E -> phy 0x17
    localparam logic [17:0] ADDR_C = 18'h3FFFC;

    task automatic t_reset();
        chk("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1", "done after reset", {31'd0, done}, 32'd0);
        chk("R1", "mdc after reset", {31'd0, mdc}, 32'd0);
        chk("R1", "oe after reset", {31'd0, mdio_oe}, 32'd0);
    endtask

    task automatic t_write();
        run_op(2'b01, ADDR_A, 32'hDEAD_BEEF, 32'h0, 1'b0);
        chk("R5", "frame count", fcount, 3);
        chk_frame("R3", 0, 1'b0, 5'h18, 5'd0, 16'h0155);
        chk_frame("R5", 1, 1'b0, 5'h15, 5'h16, 16'hBEEF);
        chk_frame("R5", 2, 1'b0, 5'h15, 5'h17, 16'hDEAD);
        chk("R4", "settle gap ok", {31'd0, (f_first[1] - f_last[0]) >= SETTLE_CYC}, 32'd1);
        chk("R9", "preamble", {31'd0, f_pre[0]}, 32'd1);
        chk("R9", "start", {30'd0, f_st[0]}, 32'd1);
        chk("R9", "write opcode", {30'd0, f_op[0]}, 32'd1);
        chk("R9", "write turnaround", {30'd0, f_ta[1]}, 32'd2);
        chk("R9", "write oe", {31'd0, f_oeok[2]}, 32'd1);
        chk("R6", "write returns word", got, 32'hDEAD_BEEF);
    endtask

    task automatic t_read();
        run_op(2'b00, ADDR_A, 32'h0, 32'h0, 1'b0);
        chk("R6", "frame count", fcount, 3);
        chk_frame("R3", 0, 1'b0, 5'h18, 5'd0, 16'h0155);
        chk_frame("R6", 1, 1'b1, 5'h15, 5'h16, 16'hBEEF);
        chk_frame("R6", 2, 1'b1, 5'h15, 5'h17, 16'hDEAD);
        chk("R6", "read data", got, 32'hDEAD_BEEF);
        chk("R9", "read opcode", {30'd0, f_op[1]}, 32'd2);
        chk("R9", "read releases bus", {31'd0, f_oeok[1]}, 32'd1);
        chk("R4", "settle gap ok", {31'd0, (f_first[1] - f_last[0]) >= SETTLE_CYC}, 32'd1);
    endtask

    task automatic t_split();
        run_op(2'b01, ADDR_B, 32'h1357_00A5, 32'h0, 1'b0);
        chk_frame("R2", 0, 1'b0, 5'h18, 5'd0, 16'h0001);
        chk_frame("R2", 1, 1'b0, 5'h10, 5'h06, 16'h00A5);
        chk_frame("R2", 2, 1'b0, 5'h10, 5'h07, 16'h1357);
    endtask

    task automatic t_rmw();
        mem[mkey(9'h1FF, 5'h17, 5'h1E)] = 16'h5678;
        mem[mkey(9'h1FF, 5'h17, 5'h1F)] = 16'h1234;
        run_op(2'b10, ADDR_C, 32'h0000_AB00, 32'h0000_FF00, 1'b0);
        chk("R7", "frame count", fcount, 5);
        chk_frame("R7", 0, 1'b0, 5'h18, 5'd0, 16'h01FF);
        chk_frame("R7", 1, 1'b1, 5'h17, 5'h1E, 16'h5678);
        chk_frame("R7", 2, 1'b1, 5'h17, 5'h1F, 16'h1234);
        chk_frame("R7", 3, 1'b0, 5'h17, 5'h1E, 16'hAB78);
        chk_frame("R7", 4, 1'b0, 5'h17, 5'h1F, 16'h1234);
        chk("R7", "rmw result", got, 32'h1234_AB78);
    endtask

    task automatic t_set_clear();
        run_op(2'b10, ADDR_C, 32'h8000_0001, 32'h0, 1'b0);
        chk("R8", "set bits result", got, 32'h9234_AB79);
        chk("R8", "set bits stored hi", {16'd0, mem[mkey(9'h1FF, 5'h17, 5'h1F)]}, 32'h9234);
        run_op(2'b11, ADDR_C, 32'h0, 32'h0000_000F, 1'b0);
        chk("R8", "clear bits result", got, 32'h9234_AB70);
        chk("R8", "clear bits stored lo", {16'd0, mem[mkey(9'h1FF, 5'h17, 5'h1E)]}, 32'hAB70);
    endtask

    task automatic t_busy();
        run_op(2'b00, ADDR_A, 32'h0, 32'h0, 1'b1);
        chk("R10", "frames of busy op", fcount, 3);
        chk("R10", "read data unaffected", got, 32'hDEAD_BEEF);
        repeat (10) @(negedge clk);
        chk("R10", "no extra frames", fcount, 3);
        run_op(2'b00, 18'h00444, 32'h0, 32'h0, 1'b0);
        chk("R10", "ignored write absent", got, 32'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_split();
        t_rmw();
        t_set_clear();
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule